// File: doc/BRIEF.md
# Short-Training Delay-Correlation Boundary Finder

This block finds the coarse symbol boundary of a packet whose preamble is made of repeated 16-sample segments. It also captures the complex value from which the coarse carrier frequency offset is derived. Each accepted complex baseband sample is multiplied by the conjugate of the sample accepted 16 samples earlier. A recursive running sum keeps the 16 most recent of these products, so each new sample costs one addition and one subtraction per component.

The search begins once the detection logic upstream raises the enable, which it does after the front of the preamble has been spent on signal detection and gain settling. The magnitude of each correlation is approximated as |re| + |im|. A peak seeker follows the rise and fall of this metric and halves a search step every time the slope reverses. When the step reaches one sample, the seeker declares the boundary. At that moment it emits a single strobe with the index of the largest correlation seen and the complex correlation held at that index. The angle of that value, divided by the lag, gives the per-sample phase rotation. The angle computation is done downstream.

Top module: `stf_boundary_det`

## Requirements
- R1: After reset, bnd_stb is 0 and bnd_idx, bnd_re and bnd_im are all zero.
- R2: The complex value reported for accepted sample n is the sum over k = n-15..n of x[k]·conj(x[k-16]), that is re = Σ(I[k]·I[k-16] + Q[k]·Q[k-16]) and im = Σ(Q[k]·I[k-16] − I[k]·Q[k-16]). Samples that precede the current enable session count as zero.
- R3: The candidate metric is |re| + |im|. The reported entry is the candidate with the largest metric since the search began. On a tie, the earlier candidate is kept.
- R4: Only samples with index 31 or higher (lag + window − 1) are candidates. Larger correlations at earlier indices never reach the outputs.
- R5: The slope starts as rising. A metric strictly below the previous one while rising, or strictly above it while falling, is a turn; an equal metric leaves the slope unchanged. The step starts at 8 and halves at each turn. The turn that brings it to 1 declares the boundary, and at most one single-cycle bnd_stb pulse is produced per enable session.
- R6: Indices count accepted samples from 0, starting at the first one after det_en rises. The count is 8 bits wide and saturates at 255.
- R7: A cycle with smp_vld low changes no correlation, index or seeker state, so the result does not depend on gaps in the stream.
- R8: While det_en is low, the sample history, the running sums, the index count, the seeker and the outputs are cleared to zero by the next clock edge. A new session starts fresh.
- R9: bnd_stb goes high on the clock edge directly after the edge that accepted the sample causing the final turn.
- R10: After the pulse, bnd_idx, bnd_re and bnd_im hold their values while det_en stays high, whatever samples follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Search enable from the signal detector; low clears the block |
| smp_vld | input | 1 | Sample qualifier |
| smp_i | input | 10 | In-phase sample, signed |
| smp_q | input | 10 | Quadrature sample, signed |
| bnd_stb | output | 1 | One-cycle pulse when the boundary is declared |
| bnd_idx | output | 8 | Index of the peak correlation |
| bnd_re | output | 25 | Real part of the correlation at the peak, signed |
| bnd_im | output | 25 | Imaginary part of the correlation at the peak, signed |

## Verification
The assertions check several properties on every cycle. The running sums are frozen in gap cycles, and the block is cleared while the enable is low. Every strobe is a lone pulse that follows a correlation result and names an index past the warm-up region. The reported peak holds once it has been declared. Other behaviour can only be shown by the bench's scenarios, which compare the design against a model built from the requirements: the arithmetic of the lagged products, which candidate wins, the exact turn on which the boundary fires, and that gapped, rotated or restarted streams give the same answer as clean ones.

// File: rtl/stf_det_pkg.sv
package stf_det_pkg;

   typedef enum logic {
      SLOPE_FALL = 1'b0,
      SLOPE_RISE = 1'b1
   } slope_e;

   // width of a running sum of WIN products of two DW-bit complex samples
   function automatic int unsigned acc_width(int unsigned dw, int unsigned win);
      return 2 * dw + 1 + ((win <= 1) ? 1 : $clog2(win));
   endfunction

endpackage

// File: rtl/stf_tap_line.sv
module stf_tap_line #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (W < 1 || DEPTH < 0) begin : g_bad_cfg
      $error("stf_tap_line: W must be positive and DEPTH non-negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else if (DEPTH == 1) begin : g_one
      logic [W-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stage <= '0;
         else if (clr) stage <= '0;
         else if (adv) stage <= din;
      end
      assign dout = stage;
   end else begin : g_chain
      logic [DEPTH-1:0][W-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stage <= '0;
         else if (clr) stage <= '0;
         else if (adv) stage <= {stage[DEPTH-2:0], din};
      end
      assign dout = stage[DEPTH-1];
   end

endmodule

// File: rtl/stf_lag_corr.sv
module stf_lag_corr #(
   parameter int DW   = 10,
   parameter int LAG  = 16,
   parameter int WIN  = 16,
   parameter int IDXW = 8,
   parameter int SW   = stf_det_pkg::acc_width(DW, WIN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 in_vld,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   output logic                 c_vld,
   output logic [IDXW-1:0]      c_idx,
   output logic signed [SW-1:0] c_re,
   output logic signed [SW-1:0] c_im
);

   localparam int PW   = 2 * DW + 1;
   localparam int WARM = LAG + WIN - 1;

   if (LAG < 1 || WIN < 1 || DW < 2) begin : g_bad_cfg
      $error("stf_lag_corr: LAG, WIN must be positive and DW at least 2");
   end
   if (WARM >= (1 << IDXW) - 1) begin : g_bad_idx
      $error("stf_lag_corr: IDXW too narrow for the warm-up span");
   end

   logic                  clr, adv;
   logic [2*DW-1:0]       old_pk;
   logic signed [DW-1:0]  old_i, old_q;
   logic signed [PW-1:0]  ai, aq, bi, bq, prod_re, prod_im;
   logic [2*PW-1:0]       drop_pk;
   logic signed [PW-1:0]  drop_re, drop_im;
   logic [IDXW-1:0]       cnt;

   assign clr = !en;
   assign adv = en && in_vld;

   stf_tap_line #(.W(2*DW), .DEPTH(LAG)) u_smp_line (
      .clk (clk), .rst_n (rst_n), .clr (clr), .adv (adv),
      .din ({in_i, in_q}), .dout (old_pk)
   );

   assign old_i = old_pk[2*DW-1:DW];
   assign old_q = old_pk[DW-1:0];

   assign ai = PW'(in_i);
   assign aq = PW'(in_q);
   assign bi = PW'(old_i);
   assign bq = PW'(old_q);

   // newest sample times the conjugate of the lagged one
   assign prod_re = ai * bi + aq * bq;
   assign prod_im = aq * bi - ai * bq;

   stf_tap_line #(.W(2*PW), .DEPTH(WIN)) u_prod_line (
      .clk (clk), .rst_n (rst_n), .clr (clr), .adv (adv),
      .din ({prod_re, prod_im}), .dout (drop_pk)
   );

   assign drop_re = drop_pk[2*PW-1:PW];
   assign drop_im = drop_pk[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_re  <= '0;
         c_im  <= '0;
         cnt   <= '0;
         c_idx <= '0;
         c_vld <= 1'b0;
      end else if (clr) begin
         c_re  <= '0;
         c_im  <= '0;
         cnt   <= '0;
         c_idx <= '0;
         c_vld <= 1'b0;
      end else begin
         c_vld <= adv && (cnt >= IDXW'(WARM));
         if (adv) begin
            c_re  <= c_re + SW'(prod_re) - SW'(drop_re);
            c_im  <= c_im + SW'(prod_im) - SW'(drop_im);
            c_idx <= cnt;
            if (cnt != '1) cnt <= cnt + 1'b1;
         end
      end
   end

   p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !in_vld) |=> ($stable(c_re) && $stable(c_im) && $stable(c_idx) && !c_vld))
      else $error("R7: sums moved in a gap cycle");

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (c_re == '0 && c_im == '0 && !c_vld))
      else $error("R8: correlator not cleared");

endmodule

// File: rtl/stf_peak_seek.sv
module stf_peak_seek #(
   parameter int SW        = 25,
   parameter int IDXW      = 8,
   parameter int STEP_LOG2 = 3,
   parameter int WARM      = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 c_vld,
   input  logic [IDXW-1:0]      c_idx,
   input  logic signed [SW-1:0] c_re,
   input  logic signed [SW-1:0] c_im,
   output logic                 bnd_stb,
   output logic [IDXW-1:0]      pk_idx,
   output logic signed [SW-1:0] pk_re,
   output logic signed [SW-1:0] pk_im
);

   import stf_det_pkg::*;

   localparam int MW  = SW + 1;
   localparam int SPW = STEP_LOG2 + 1;

   if (STEP_LOG2 < 1 || SW < 2) begin : g_bad_cfg
      $error("stf_peak_seek: STEP_LOG2 must be at least 1");
   end

   logic [SW-1:0]          mag_re, mag_im;
   logic [MW-1:0]          metric, prev_m, best_m, nb_m;
   logic [IDXW-1:0]        best_idx, nb_idx;
   logic signed [SW-1:0]   best_re, best_im, nb_re, nb_im;
   logic [SPW-1:0]         step;
   slope_e                 slope;
   logic                   seen, done, take, up, dn, turn, fire, keep_new;

   assign mag_re = c_re[SW-1] ? SW'(-c_re) : SW'(c_re);
   assign mag_im = c_im[SW-1] ? SW'(-c_im) : SW'(c_im);
   assign metric = {1'b0, mag_re} + {1'b0, mag_im};

   assign take     = c_vld && !done;
   assign up       = metric > prev_m;
   assign dn       = metric < prev_m;
   assign turn     = seen && ((up && slope == SLOPE_FALL) || (dn && slope == SLOPE_RISE));
   assign fire     = take && turn && (step == SPW'(2));
   assign keep_new = !seen || (metric > best_m);

   assign nb_m   = keep_new ? metric : best_m;
   assign nb_idx = keep_new ? c_idx  : best_idx;
   assign nb_re  = keep_new ? c_re   : best_re;
   assign nb_im  = keep_new ? c_im   : best_im;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !en) begin
         seen     <= 1'b0;
         done     <= 1'b0;
         prev_m   <= '0;
         slope    <= SLOPE_RISE;
         step     <= SPW'(1) << STEP_LOG2;
         best_m   <= '0;
         best_idx <= '0;
         best_re  <= '0;
         best_im  <= '0;
         bnd_stb  <= 1'b0;
         pk_idx   <= '0;
         pk_re    <= '0;
         pk_im    <= '0;
      end else begin
         bnd_stb <= 1'b0;
         if (take) begin
            seen     <= 1'b1;
            prev_m   <= metric;
            best_m   <= nb_m;
            best_idx <= nb_idx;
            best_re  <= nb_re;
            best_im  <= nb_im;
            if (!seen)   slope <= SLOPE_RISE;
            else if (up) slope <= SLOPE_RISE;
            else if (dn) slope <= SLOPE_FALL;
            if (turn) step <= step >> 1;
            if (fire) begin
               done    <= 1'b1;
               bnd_stb <= 1'b1;
               pk_idx  <= nb_idx;
               pk_re   <= nb_re;
               pk_im   <= nb_im;
            end
         end
      end
   end

   p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_stb |=> !bnd_stb)
      else $error("R5: strobe longer than one cycle");

   p_after_warm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_stb |-> (pk_idx >= IDXW'(WARM)))
      else $error("R4: peak inside warm-up span");

   p_stb_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_stb |-> $past(c_vld))
      else $error("R9: strobe without a correlation result");

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && en) |=> ($stable(pk_idx) && $stable(pk_re) && $stable(pk_im) && !bnd_stb))
      else $error("R10: peak changed after declaration");

endmodule

// File: rtl/stf_boundary_det.sv
module stf_boundary_det #(
   parameter int DW        = 10,
   parameter int LAG       = 16,
   parameter int WIN       = 16,
   parameter int IDXW      = 8,
   parameter int STEP_LOG2 = 3,
   parameter int SW        = stf_det_pkg::acc_width(DW, WIN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 det_en,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] smp_i,
   input  logic signed [DW-1:0] smp_q,
   output logic                 bnd_stb,
   output logic [IDXW-1:0]      bnd_idx,
   output logic signed [SW-1:0] bnd_re,
   output logic signed [SW-1:0] bnd_im
);

   localparam int WARM = LAG + WIN - 1;

   logic                 c_vld;
   logic [IDXW-1:0]      c_idx;
   logic signed [SW-1:0] c_re, c_im;

   stf_lag_corr #(
      .DW (DW), .LAG (LAG), .WIN (WIN), .IDXW (IDXW), .SW (SW)
   ) u_corr (
      .clk (clk), .rst_n (rst_n), .en (det_en), .in_vld (smp_vld),
      .in_i (smp_i), .in_q (smp_q),
      .c_vld (c_vld), .c_idx (c_idx), .c_re (c_re), .c_im (c_im)
   );

   stf_peak_seek #(
      .SW (SW), .IDXW (IDXW), .STEP_LOG2 (STEP_LOG2), .WARM (WARM)
   ) u_seek (
      .clk (clk), .rst_n (rst_n), .en (det_en),
      .c_vld (c_vld), .c_idx (c_idx), .c_re (c_re), .c_im (c_im),
      .bnd_stb (bnd_stb), .pk_idx (bnd_idx), .pk_re (bnd_re), .pk_im (bnd_im)
   );

endmodule

// File: tb/stf_boundary_det_test.sv
`timescale 1ns/1ps
module stf_boundary_det_test;

   localparam int SN = 150;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               det_en = 1'b0;
   logic               smp_vld = 1'b0;
   logic signed [9:0]  smp_i = '0;
   logic signed [9:0]  smp_q = '0;
   logic               bnd_stb;
   logic [7:0]         bnd_idx;
   logic signed [24:0] bnd_re, bnd_im;

   always #4 clk = ~clk;

   stf_boundary_det uut (
      .clk (clk), .rst_n (rst_n), .det_en (det_en), .smp_vld (smp_vld),
      .smp_i (smp_i), .smp_q (smp_q),
      .bnd_stb (bnd_stb), .bnd_idx (bnd_idx), .bnd_re (bnd_re), .bnd_im (bnd_im)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   int xi [SN];
   int xq [SN];
   int acc_edge [SN];
   int exp_trig, exp_idx, exp_re, exp_im;

   // scenario rows: [15:8] seed, [7:6] quarter turns per segment, [2] gaps, [1] early boost, [0] aborted pre-run
   localparam logic [15:0] SCN [7] = '{
      16'hA500, 16'h3C40, 16'h7180, 16'h5AC0,
      16'h9904, 16'h4E42, 16'hC387
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic build(input logic [15:0] row);
      logic [7:0] lf;
      int amp, pi, pq, t, q;
      lf = (row[15:8] == 8'd0) ? 8'h1D : row[15:8];
      for (int n = 0; n < SN; n++) begin
         lf  = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         amp = 20 + int'(lf[4:0]);
         if (row[1] && n < 31) amp = 120;
         pi = 3 - 2 * (n % 4);
         pq = ((n / 4) % 2 == 1) ? 2 : -2;
         pi = pi * amp;
         pq = pq * amp;
         q = (int'(row[7:6]) * (n / 16)) % 4;
         for (int r = 0; r < q; r++) begin
            t  = pi;
            pi = -pq;
            pq = t;
         end
         xi[n] = pi;
         xq[n] = pq;
      end
   endtask

   // reference from R2..R5
   task automatic model();
      int cre, cim, m, prev, best, step;
      bit seen, rise, up, dn, turn;
      exp_trig = -1; exp_idx = 0; exp_re = 0; exp_im = 0;
      seen = 0; rise = 1; step = 8; prev = 0; best = 0;
      for (int n = 31; n < SN && exp_trig < 0; n++) begin
         cre = 0; cim = 0;
         for (int k = n - 15; k <= n; k++) begin
            if (k >= 16) begin
               cre += xi[k] * xi[k-16] + xq[k] * xq[k-16];
               cim += xq[k] * xi[k-16] - xi[k] * xq[k-16];
            end
         end
         m = iabs(cre) + iabs(cim);
         if (!seen) begin
            seen = 1; prev = m; best = m;
            exp_idx = n; exp_re = cre; exp_im = cim;
         end else begin
            if (m > best) begin
               best = m; exp_idx = n; exp_re = cre; exp_im = cim;
            end
            up = m > prev;
            dn = m < prev;
            turn = (up && !rise) || (dn && rise);
            if (up) rise = 1;
            if (dn) rise = 0;
            prev = m;
            if (turn) begin
               step = step / 2;
               if (step == 1) exp_trig = n;
            end
         end
      end
   endtask

   task automatic run_scn(input logic [15:0] row);
      int n, e, tail, stb_cnt, stb_edge, cap_idx, cap_re, cap_im;
      build(row);
      model();
      if (row[0]) begin
         det_en = 1'b1;
         for (int c = 0; c < 20; c++) begin
            smp_vld = 1'b1;
            smp_i = 10'(300 - 17 * c);
            smp_q = 10'(-250 + 23 * c);
            @(negedge clk);
         end
      end
      det_en = 1'b0; smp_vld = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(bnd_idx == 0 && bnd_re == 0 && bnd_im == 0 && !bnd_stb,
          "R8 clear while disabled", int'(bnd_re), 0);
      det_en = 1'b1;
      n = 0; e = 0; tail = 0; stb_cnt = 0; stb_edge = 0;
      cap_idx = 0; cap_re = 0; cap_im = 0;
      while (n < SN || tail < 6) begin
         if (n < SN && !(row[2] && (e % 3 == 2))) begin
            smp_vld = 1'b1;
            smp_i = 10'(xi[n]);
            smp_q = 10'(xq[n]);
            acc_edge[n] = e + 1;
            n++;
         end else begin
            smp_vld = 1'b0;
            if (n == SN) tail++;
         end
         @(negedge clk);
         e++;
         if (bnd_stb) begin
            stb_cnt++;
            stb_edge = e;
            cap_idx = int'(bnd_idx);
            cap_re = int'(bnd_re);
            cap_im = int'(bnd_im);
         end
      end
      smp_vld = 1'b0;
      chk(stb_cnt == ((exp_trig >= 0) ? 1 : 0), "R5 pulse count", stb_cnt, (exp_trig >= 0) ? 1 : 0);
      if (exp_trig >= 0) begin
         chk(cap_idx == exp_idx, "R3 R4 R6 peak index", cap_idx, exp_idx);
         chk(cap_re == exp_re, "R2 correlation real", cap_re, exp_re);
         chk(cap_im == exp_im, "R2 correlation imag", cap_im, exp_im);
         chk(stb_edge == acc_edge[exp_trig] + 1, "R9 strobe edge", stb_edge, acc_edge[exp_trig] + 1);
         chk(int'(bnd_idx) == cap_idx && int'(bnd_re) == cap_re && int'(bnd_im) == cap_im,
             "R10 outputs held", int'(bnd_re), cap_re);
      end
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!bnd_stb && bnd_idx == 0 && bnd_re == 0 && bnd_im == 0, "R1 reset outputs", int'(bnd_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bnd_stb && bnd_re == 0 && bnd_im == 0, "R1 idle after reset", int'(bnd_re), 0);

      // R7 gaps, R4 early boost, R8 aborted pre-run are table columns
      foreach (SCN[s]) run_scn(SCN[s]);

      // R7: gap-only stream leaves the held result alone and raises no pulse
      for (int c = 0; c < 10; c++) begin
         smp_vld = 1'b0;
         smp_i = 10'sd200;
         smp_q = -10'sd200;
         @(negedge clk);
         chk(!bnd_stb, "R7 no pulse in gaps", int'(bnd_stb), 0);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule